// File: doc/BRIEF.md
# Console Transmit Register Port

This block is the transmit half of a console serial port. A processor reaches it through a small register port that has two addresses. The status register at address 0 holds a ready flag and an interrupt enable. The character buffer at address 1 can only be written. A buffer write stores a character and marks the transmitter busy. After a parameterised delay the block offers the character to a downstream serializer for exactly one cycle.

If the serializer accepts the character in that cycle, the ready flag returns and an interrupt is raised when interrupts are enabled. If the serializer refuses, the offer is withdrawn and repeated after a shorter retry delay. The ready flag stays clear until some offer is accepted.

An output-mode input selects how the character is shaped. It can pass all 8 bits, mask the character to 7 bits, or mask to 7 bits and quietly discard non-printing characters. A discarded character still completes as though it had been sent.

Top module: `con_tx_port`

## Requirements
- R1: After synchronous reset the status reads 0x80 (ready set, enable clear), `irq` is low, `tx_valid` is low and any character in flight is abandoned, so no offer follows the reset.
- R2: The status word has ready at bit 7 and enable at bit 6, and bits 5:0 always read 0. A status write changes only the enable bit; bit 7 of the written data has no effect on the ready flag.
- R3: A write to address 1 stores `reg_wdata[7:0]` as the character. On the next cycle ready reads 0 and `irq` is low.
- R4: The character is offered on `tx_valid`/`tx_data` in the cycle that follows the DELAY-th rising edge after the buffer write. The offer lasts exactly one cycle, and ready stays 0 while it is made.
- R5: When `tx_ready` is high during an offer, ready reads 1 on the next cycle, and `irq` goes high at the same time if enable is set.
- R6: When `tx_ready` is low during an offer, `tx_valid` drops and ready stays 0. The same character is offered again in the cycle that follows the RETRY-th edge after the refused offer.
- R7: A status write with bit 6 = 0 clears `irq` on the next cycle. A status write with bit 6 = 1 raises `irq` only when ready is 1 and enable was 0 before the write. `irq` is never high unless both ready and enable are 1.
- R8: `out_mode` 0 (or 3) sends all 8 bits. Mode 1 sends the character with bit 7 forced to 0.
- R9: In mode 2 bit 7 is forced to 0. A resulting code below 0x20 (except 0x08, 0x09, 0x0A, 0x0D) or equal to 0x7F is never offered, and ready returns on the DELAY-th edge after the write.
- R10: A buffer write while busy replaces the pending character and restarts the full delay; the earlier character is never offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = character buffer |
| reg_wdata | input | 8 | Write data |
| stat_rdata | output | 8 | Status word: bit 7 ready, bit 6 enable |
| irq | output | 1 | Transmit interrupt request |
| out_mode | input | 2 | Output shaping mode |
| tx_valid | output | 1 | Character offered downstream |
| tx_data | output | 8 | Shaped character |
| tx_ready | input | 1 | Downstream accepts the offer |

## Verification
Most internal faults surface at the ports within a few cycles. A wrong delay counter moves the one-cycle `tx_valid` pulse away from its expected cycle. A lost completion leaves bit 7 of the status low for good. A bad enable/ready combination shows an `irq` that disagrees with the status word on the very next cycle. Shaping faults appear as a wrong `tx_data` on the offer cycle, or as an offer where a suppressed character should simply complete. The bench checks each of these every cycle against a behavioural model.

// File: rtl/con_tx_pkg.sv
package con_tx_pkg;

    localparam int CHAR_W   = 8;
    localparam int READY_BIT = 7;
    localparam int ENA_BIT  = 6;

    typedef enum logic [1:0] {
        TXM_8BIT = 2'd0,
        TXM_7BIT = 2'd1,
        TXM_7SUP = 2'd2,
        TXM_RSV  = 2'd3
    } tx_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_OFFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] code;
        logic              drop;
    } tx_char_t;

    function automatic logic is_printing(input logic [6:0] c);
        logic ctl_ok;
        ctl_ok = (c == 7'h08) || (c == 7'h09) || (c == 7'h0A) || (c == 7'h0D);
        return ((c >= 7'h20) && (c != 7'h7F)) || ctl_ok;
    endfunction

    function automatic tx_char_t shape_char(input logic [CHAR_W-1:0] raw,
                                            input tx_mode_e m);
        tx_char_t r;
        r.drop = 1'b0;
        case (m)
            TXM_7BIT: r.code = {1'b0, raw[6:0]};
            TXM_7SUP: begin
                r.code = {1'b0, raw[6:0]};
                r.drop = !is_printing(raw[6:0]);
            end
            default:  r.code = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/con_tx_timer.sv
module con_tx_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/con_tx_filter.sv
module con_tx_filter
    import con_tx_pkg::*;
#(
    parameter bit SUPPRESS_EN = 1'b1
) (
    input  logic [CHAR_W-1:0] raw,
    input  logic [1:0]        mode,
    output tx_char_t          shaped
);
    generate
        if (SUPPRESS_EN) begin : g_full
            assign shaped = shape_char(raw, tx_mode_e'(mode));
        end else begin : g_nosup
            tx_mode_e eff_mode;
            assign eff_mode = (tx_mode_e'(mode) == TXM_7SUP) ? TXM_7BIT : tx_mode_e'(mode);
            assign shaped   = shape_char(raw, eff_mode);
        end
    endgenerate
endmodule

// File: rtl/con_tx_seq.sv
module con_tx_seq
    import con_tx_pkg::*;
#(
    parameter int DELAY = 6,
    parameter int RETRY = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             expired,
    input  logic             drop,
    input  logic             tx_ready,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_run,
    output logic             tx_valid,
    output logic             complete
);
    localparam logic [CNT_W-1:0] FIRST_VAL = CNT_W'(DELAY - 1);
    localparam logic [CNT_W-1:0] RETRY_VAL = CNT_W'(RETRY - 1);

    seq_state_e state_q, state_n;

    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = FIRST_VAL;
        complete = 1'b0;
        if (restart) begin
            state_n  = SEQ_WAIT;
            tmr_load = 1'b1;
        end else begin
            case (state_q)
                SEQ_WAIT: begin
                    if (expired) begin
                        if (drop) begin
                            state_n  = SEQ_IDLE;
                            complete = 1'b1;
                        end else begin
                            state_n = SEQ_OFFER;
                        end
                    end
                end
                SEQ_OFFER: begin
                    if (tx_ready) begin
                        state_n  = SEQ_IDLE;
                        complete = 1'b1;
                    end else begin
                        state_n  = SEQ_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = RETRY_VAL;
                    end
                end
                default: state_n = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_n;
    end

    assign tmr_run  = (state_q == SEQ_WAIT);
    assign tx_valid = (state_q == SEQ_OFFER);
endmodule

// File: rtl/con_tx_regs.sv
module con_tx_regs
    import con_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic              wr_buf,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              complete,
    output logic [CHAR_W-1:0] char_q,
    output logic [CHAR_W-1:0] stat_word,
    output logic              irq_q
);
    logic ready_q, ena_q;
    logic ena_n, irq_n;

    always_comb begin
        ena_n = wr_stat ? wdata[ENA_BIT] : ena_q;
        irq_n = irq_q;
        if (wr_stat && !wdata[ENA_BIT]) begin
            irq_n = 1'b0;
        end else if (wr_stat && ready_q && !ena_q) begin
            irq_n = 1'b1;
        end
        if (complete && ena_n) begin
            irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            char_q  <= '0;
            ready_q <= 1'b1;
            ena_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else if (wr_buf) begin
            char_q  <= wdata;
            ready_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (complete) ready_q <= 1'b1;
            ena_q <= ena_n;
            irq_q <= irq_n;
        end
    end

    always_comb begin
        stat_word            = '0;
        stat_word[READY_BIT] = ready_q;
        stat_word[ENA_BIT]   = ena_q;
    end
endmodule

// File: rtl/con_tx_port.sv
module con_tx_port
    import con_tx_pkg::*;
#(
    parameter int DELAY       = 6,
    parameter int RETRY       = 3,
    parameter bit SUPPRESS_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  stat_rdata,
    output logic        irq,
    input  logic [1:0]  out_mode,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready
);
    localparam int SPAN  = (DELAY > RETRY) ? DELAY : RETRY;
    localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;

    logic              wr_stat, wr_buf;
    logic              complete, expired;
    logic              tmr_load, tmr_run;
    logic [CNT_W-1:0]  tmr_val;
    logic [CHAR_W-1:0] char_q;
    tx_char_t          shaped;

    assign wr_stat = reg_wr && !reg_addr;
    assign wr_buf  = reg_wr && reg_addr;

    con_tx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_stat   (wr_stat),
        .wr_buf    (wr_buf),
        .wdata     (reg_wdata),
        .complete  (complete),
        .char_q    (char_q),
        .stat_word (stat_rdata),
        .irq_q     (irq)
    );

    con_tx_filter #(.SUPPRESS_EN(SUPPRESS_EN)) u_filter (
        .raw    (char_q),
        .mode   (out_mode),
        .shaped (shaped)
    );

    con_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expired  (expired)
    );

    con_tx_seq #(.DELAY(DELAY), .RETRY(RETRY), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_buf),
        .expired  (expired),
        .drop     (shaped.drop),
        .tx_ready (tx_ready),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_run  (tmr_run),
        .tx_valid (tx_valid),
        .complete (complete)
    );

    assign tx_data = shaped.code;
endmodule

// File: rtl/con_tx_port_chk.sv
module con_tx_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] stat_rdata,
    input logic       irq,
    input logic       tx_valid,
    input logic       tx_ready
);
    a_r3_write_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> (!stat_rdata[7] && !irq));

    a_r7_ena_off_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && !reg_wdata[6]) |=> !irq);

    a_r7_irq_needs_ready_ena: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_rdata[7] && stat_rdata[6]));

    a_r5_accept_sets_ready: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !(reg_wr && reg_addr)) |=> stat_rdata[7]);

    a_r6_refusal_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !(reg_wr && reg_addr)) |=> !stat_rdata[7]);

    a_r4_single_cycle_offer: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);

    a_r4_busy_while_offering: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !stat_rdata[7]);

    a_r2_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[5:0] == 6'd0);
endmodule

bind con_tx_port con_tx_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .stat_rdata (stat_rdata),
    .irq        (irq),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready)
);

// File: tb/test_con_tx_port.sv
module test_con_tx_port;
    localparam int D = 6;
    localparam int R = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [1:0] out_mode = 2'd0;
    logic       tx_ready = 1'b1;
    logic [7:0] stat_rdata;
    logic       irq, tx_valid;
    logic [7:0] tx_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    con_tx_port #(.DELAY(D), .RETRY(R), .SUPPRESS_EN(1'b1)) i_con_tx_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .stat_rdata(stat_rdata), .irq(irq),
        .out_mode(out_mode), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    always #5 clk = ~clk;

    // behavioural model state
    bit       started = 1'b0;
    int       m_wait = 0;
    bit       m_offer = 1'b0;
    bit       m_done = 1'b1, m_ie = 1'b0, m_irq = 1'b0;
    bit [7:0] m_char = 8'h00;
    int       acc_cnt = 0;
    bit [7:0] acc_last = 8'h00;

    function automatic bit [7:0] exp_code(bit [7:0] b, bit [1:0] m);
        if (m == 2'd1 || m == 2'd2) return b & 8'h7F;
        return b;
    endfunction

    function automatic bit exp_drop(bit [7:0] b, bit [1:0] m);
        int c;
        c = b & 8'h7F;
        if (m != 2'd2) return 1'b0;
        if (c == 127) return 1'b1;
        if (c >= 32) return 1'b0;
        return !(c == 8 || c == 9 || c == 10 || c == 13);
    endfunction

    always @(posedge clk) begin
        bit cmp, n_offer, new_ie;
        int n_wait;
        started <= 1'b1;
        if (rst) begin
            m_char = 0; m_done = 1; m_ie = 0; m_irq = 0; m_wait = 0; m_offer = 0;
        end else begin
            cmp = 0; n_offer = 0; n_wait = m_wait;
            if (m_offer) begin
                if (tx_ready) cmp = 1;
                else n_wait = R;
            end else if (m_wait > 0) begin
                if (m_wait == 1) begin
                    n_wait = 0;
                    if (exp_drop(m_char, out_mode)) cmp = 1;
                    else n_offer = 1;
                end else begin
                    n_wait = m_wait - 1;
                end
            end
            if (reg_wr && reg_addr) begin
                m_char = reg_wdata; m_done = 0; m_irq = 0; m_wait = D; m_offer = 0;
            end else begin
                new_ie = (reg_wr && !reg_addr) ? reg_wdata[6] : m_ie;
                if (reg_wr && !reg_addr && !reg_wdata[6]) m_irq = 0;
                else if (reg_wr && !reg_addr && m_done && !m_ie) m_irq = 1;
                if (cmp) begin
                    m_done = 1;
                    if (new_ie) m_irq = 1;
                end
                m_ie = new_ie; m_wait = n_wait; m_offer = n_offer;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk({cur_req, " status"}, stat_rdata, {m_done, m_ie, 6'd0});
            chk({cur_req, " irq"}, irq, m_irq);
            chk({cur_req, " tx_valid"}, tx_valid, m_offer);
            if (m_offer) chk({cur_req, " tx_data"}, tx_data, exp_code(m_char, out_mode));
            if (!rst && tx_valid && tx_ready) begin
                acc_cnt++;
                acc_last = tx_data;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit a, bit [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int a0;
        tick(2);
        rst = 1'b0;
        tick(1);
        cur_req = "R1";
        chk("R1 reset status", stat_rdata, 8'h80);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset tx_valid", tx_valid, 0);

        cur_req = "R2";
        wr(1'b0, 8'hFF);
        chk("R2 only enable writable", stat_rdata, 8'hC0);
        chk("R7 enable rise while ready raises irq", irq, 1);
        wr(1'b0, 8'h40);
        chk("R7 enable already set keeps irq", irq, 1);
        wr(1'b0, 8'h00);
        chk("R7 enable off clears irq", irq, 0);
        chk("R2 bit7 write ignored", stat_rdata, 8'h80);
        wr(1'b0, 8'h40);

        cur_req = "R4";
        out_mode = 2'd0;
        wr(1'b1, 8'hC1);
        chk("R3 buffer write clears ready", stat_rdata[7], 0);
        chk("R3 buffer write clears irq", irq, 0);
        tick(D - 1);
        chk("R4 no early offer", tx_valid, 0);
        tick(1);
        chk("R4 offer after delay", tx_valid, 1);
        chk("R8 8-bit data", tx_data, 8'hC1);
        tick(1);
        chk("R5 ready after accept", stat_rdata[7], 1);
        chk("R5 irq after accept", irq, 1);

        cur_req = "R8";
        out_mode = 2'd1;
        wr(1'b1, 8'hC1);
        tick(D);
        chk("R8 7-bit masks bit7", tx_data, 8'h41);
        tick(1);

        cur_req = "R6";
        out_mode = 2'd0;
        tx_ready = 1'b0;
        wr(1'b1, 8'h55);
        tick(D);
        chk("R6 first offer", tx_valid, 1);
        tick(1);
        chk("R6 offer withdrawn", tx_valid, 0);
        chk("R6 ready stays clear", stat_rdata[7], 0);
        tick(R - 1);
        chk("R6 no retry before window", tx_valid, 0);
        tick(1);
        chk("R6 retry offer", tx_valid, 1);
        chk("R6 same character", tx_data, 8'h55);
        tx_ready = 1'b1;
        tick(1);
        chk("R6 ready after retried accept", stat_rdata[7], 1);

        cur_req = "R9";
        out_mode = 2'd2;
        a0 = acc_cnt;
        wr(1'b1, 8'h87);
        tick(D);
        chk("R9 suppressed char completes", stat_rdata[7], 1);
        chk("R9 suppressed char not offered", acc_cnt, a0);
        chk("R9 suppressed completion irq", irq, 1);
        wr(1'b1, 8'hFF);
        tick(D);
        chk("R9 delete not offered", acc_cnt, a0);
        wr(1'b1, 8'h0D);
        tick(D);
        chk("R9 carriage return offered", tx_valid, 1);
        chk("R9 carriage return code", tx_data, 8'h0D);
        tick(1);

        cur_req = "R10";
        out_mode = 2'd0;
        a0 = acc_cnt;
        wr(1'b1, 8'h41);
        tick(3);
        wr(1'b1, 8'h42);
        tick(D - 1);
        chk("R10 restarted delay", tx_valid, 0);
        tick(1);
        chk("R10 replacement offered", tx_data, 8'h42);
        tick(1);
        chk("R10 one delivery only", acc_cnt, a0 + 1);
        chk("R10 last delivered", acc_last, 8'h42);

        cur_req = "R7";
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h40);
        chk("R7 enable while busy no irq", irq, 0);
        tick(D);
        chk("R7 irq on later completion", irq, 1);

        cur_req = "R1";
        a0 = acc_cnt;
        wr(1'b1, 8'h99);
        tick(2);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R1 reset mid-flight status", stat_rdata, 8'h80);
        chk("R1 reset mid-flight irq", irq, 0);
        tick(D + 2);
        chk("R1 abandoned character not sent", acc_cnt, a0);

        tick(2);
        finish_run();
    end
endmodule